// File: doc/BRIEF.md
# Endian-Configurable Word Memory Port

This block is a small byte-organised storage array with a single 32-bit word port in front of it. A requester presents a byte address, a chip enable, a direction bit and write data. On a write, the block spreads the four bytes of the word over four consecutive byte locations. On a read, it gathers four consecutive bytes back into a word and returns it one clock later.

A static order input picks how bytes map onto significance. In big-endian order the most significant byte sits at the lowest address of the word. In little-endian order the least significant byte sits there. A second static input sets the policy for word accesses whose address is not a multiple of four. Under the strict policy such an access is refused: it raises a one-cycle error flag and touches nothing. Under the permissive policy the access runs across the four consecutive bytes, and the address wraps at the top of the array.

Top module: `endian_word_mem`

## Requirements
- R1: After synchronous reset, `rdata` is 0, `err` is 0, and every byte of the array reads as 0.
- R2: With `big_endian`=1, a write at byte address A stores `wdata[31-8i:24-8i]` at byte A+i for i=0..3, so the most significant byte lands at the lowest address. For example, 0xF498B70F written at 0 puts 0xF4 at byte 0.
- R3: With `big_endian`=0, a write at byte address A stores `wdata[8i+7:8i]` at byte A+i, so the least significant byte lands at the lowest address. For example, 0xF498B70F written at 8 puts 0x0F at byte 8.
- R4: A read (`ce`=1, `wr`=0) at address A returns, on `rdata` after the next rising edge, the four bytes A..A+3 assembled in the current byte order. A word written at A and read back at A in the same order returns the written value.
- R5: An access is aligned exactly when `addr[1:0]` is 00.
- R6: When `allow_misaligned`=0 and an access with `ce`=1 is misaligned, `err` is 1 for the following cycle, `rdata` becomes 0, and no byte is written. `err` returns to 0 on the next cycle unless another such access occurs.
- R7: When `allow_misaligned`=1, a misaligned access is carried out on bytes A..A+3 taken modulo 2^ADDR_W, and `err` stays 0.
- R8: While `ce`=0 no byte is written, `rdata` keeps its value and `err` is 0 on the next cycle.
- R9: An accepted write (`ce`=1, `wr`=1) leaves `rdata` unchanged and `err` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Chip enable; when low, no access takes place |
| wr | input | 1 | Direction: 1 write, 0 read |
| addr | input | ADDR_W | Byte address of the lowest byte of the word |
| wdata | input | 32 | Write word |
| big_endian | input | 1 | Byte order: 1 big-endian, 0 little-endian |
| allow_misaligned | input | 1 | 1 carries out misaligned accesses, 0 rejects them |
| rdata | output | 32 | Read word, registered |
| err | output | 1 | Misaligned access rejected in the previous cycle |

## Verification
The value 0xF498B70F is written in one order and read back in both orders. A same-order read returns the value unchanged, while a cross-order read returns it byte-reversed, which pins down which byte sits at the lowest address. Misaligned offsets 1, 2 and 3 are tried under both policies. Under the strict policy, aligned reads before and after the refused write show that nothing changed; under the permissive policy, a write at the top of the array shows the address wrap. Idle cycles with write data present and interleaved read/write sequences tell a held `rdata` apart from a refreshed one.

// File: rtl/emem_pkg.sv
package emem_pkg;

    localparam int BYTE_W     = 8;
    localparam int WORD_BYTES = 4;
    localparam int WORD_W     = BYTE_W * WORD_BYTES;
    localparam int OFS_W      = $clog2(WORD_BYTES);

    typedef logic [BYTE_W-1:0]                  byte_t;
    typedef logic [WORD_W-1:0]                  word_t;
    typedef logic [WORD_BYTES-1:0][BYTE_W-1:0]  lanes_t;

    typedef enum logic {
        ORDER_LITTLE = 1'b0,
        ORDER_BIG    = 1'b1
    } order_e;

    typedef struct packed {
        logic do_write;
        logic do_read;
        logic reject;
    } action_s;

    // Byte lane of the word that belongs at address offset 'off'
    function automatic int lane_pos(int off, order_e ord);
        return (ord == ORDER_BIG) ? (WORD_BYTES - 1 - off) : off;
    endfunction

endpackage

// File: rtl/emem_align_chk.sv
module emem_align_chk
    import emem_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              ce,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic              allow_misaligned,
    output action_s           act
);
    logic off_word;

    always_comb begin
        off_word     = |addr[OFS_W-1:0];
        act.reject   = ce && off_word && !allow_misaligned;
        act.do_write = ce && wr  && !act.reject;
        act.do_read  = ce && !wr && !act.reject;
    end
endmodule

// File: rtl/emem_lanes.sv
module emem_lanes
    import emem_pkg::*;
(
    input  order_e ord,
    input  word_t  wdata,
    input  lanes_t rbytes,
    output lanes_t wbytes,
    output word_t  rword
);
    for (genvar g = 0; g < WORD_BYTES; g++) begin : g_scatter
        assign wbytes[g] = wdata[lane_pos(g, ord)*BYTE_W +: BYTE_W];
    end

    always_comb begin
        rword = '0;
        for (int i = 0; i < WORD_BYTES; i++) begin
            rword[lane_pos(i, ord)*BYTE_W +: BYTE_W] = rbytes[i];
        end
    end
endmodule

// File: rtl/emem_byte_array.sv
module emem_byte_array
    import emem_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  lanes_t            wbytes,
    output lanes_t            rbytes
);
    localparam int DEPTH = 1 << ADDR_W;

    byte_t             cells [DEPTH];
    logic [ADDR_W-1:0] idx   [WORD_BYTES];

    for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
        assign idx[g]    = addr + ADDR_W'(g);
        assign rbytes[g] = cells[idx[g]];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < DEPTH; c++) cells[c] <= '0;
        end else if (we) begin
            for (int i = 0; i < WORD_BYTES; i++) cells[idx[i]] <= wbytes[i];
        end
    end
endmodule

// File: rtl/endian_word_mem.sv
module endian_word_mem
    import emem_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic              big_endian,
    input  logic              allow_misaligned,
    output logic [31:0]       rdata,
    output logic              err
);
    action_s act;
    order_e  ord;
    lanes_t  wbytes;
    lanes_t  rbytes;
    word_t   rword;
    word_t   rdata_q;
    logic    err_q;

    assign ord = big_endian ? ORDER_BIG : ORDER_LITTLE;

    emem_align_chk #(.ADDR_W(ADDR_W)) align_i (
        .ce(ce), .wr(wr), .addr(addr),
        .allow_misaligned(allow_misaligned), .act(act)
    );

    emem_lanes lanes_i (
        .ord(ord), .wdata(wdata), .rbytes(rbytes),
        .wbytes(wbytes), .rword(rword)
    );

    emem_byte_array #(.ADDR_W(ADDR_W)) array_i (
        .clk(clk), .rst(rst), .we(act.do_write), .addr(addr),
        .wbytes(wbytes), .rbytes(rbytes)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            err_q <= act.reject;
            if (act.reject)       rdata_q <= '0;
            else if (act.do_read) rdata_q <= rword;
        end
    end

    assign rdata = rdata_q;
    assign err   = err_q;
endmodule

// File: rtl/emem_checker.sv
module emem_checker #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              ce,
    input logic              wr,
    input logic [ADDR_W-1:0] addr,
    input logic              allow_misaligned,
    input logic [31:0]       rdata,
    input logic              err
);
    AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        err |-> $past(ce && (addr[1:0] != 2'b00) && !allow_misaligned)); // R6

    AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (rst)
        err |-> (rdata == 32'h0)); // R6

    AST_ALIGNED_NO_ERR: assert property (@(posedge clk) disable iff (rst)
        (ce && addr[1:0] == 2'b00) |=> !err); // R5

    AST_PERMISSIVE_NO_ERR: assert property (@(posedge clk) disable iff (rst)
        (ce && allow_misaligned) |=> !err); // R7

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !ce |=> (!err && $stable(rdata))); // R8

    AST_WRITE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (ce && wr && (addr[1:0] == 2'b00 || allow_misaligned)) |=> (!err && $stable(rdata))); // R9
endmodule

bind endian_word_mem emem_checker #(.ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst(rst), .ce(ce), .wr(wr), .addr(addr),
    .allow_misaligned(allow_misaligned), .rdata(rdata), .err(err)
);

// File: tb/endian_word_mem_tb_top.sv
`timescale 1ns/1ps
module endian_word_mem_tb_top;
    localparam int AW    = 6;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ce = 1'b0, wr = 1'b0, big = 1'b0, allow = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          err;

    int checks = 0;
    int failures = 0;

    logic [7:0]  mdl [DEPTH];
    logic [31:0] mdl_r = '0;

    always #2 clk = ~clk;

    endian_word_mem #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst(rst), .ce(ce), .wr(wr), .addr(addr), .wdata(wdata),
        .big_endian(big), .allow_misaligned(allow), .rdata(rdata), .err(err)
    );

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] mdl_word(int a, bit be);
        logic [31:0] w = '0;
        for (int i = 0; i < 4; i++) begin
            if (be) w[31-8*i -: 8] = mdl[(a + i) % DEPTH];
            else    w[8*i +: 8]    = mdl[(a + i) % DEPTH];
        end
        return w;
    endfunction

    // One access: drive at negedge, sample after the capturing edge, compare with the model
    task automatic access(string tag, bit c, bit w, int a, logic [31:0] d, bit be, bit al);
        bit exp_e;
        @(negedge clk);
        ce = c; wr = w; addr = AW'(a); wdata = d; big = be; allow = al;
        exp_e = 1'b0;
        if (c) begin
            if ((a % 4) != 0 && !al) begin
                exp_e = 1'b1;
                mdl_r = '0;
            end else if (w) begin
                for (int i = 0; i < 4; i++)
                    mdl[(a + i) % DEPTH] = be ? d[31-8*i -: 8] : d[8*i +: 8];
            end else begin
                mdl_r = mdl_word(a, be);
            end
        end
        @(negedge clk);
        ce = 1'b0; wr = 1'b0;
        check({tag, " rdata"}, rdata, mdl_r);
        check({tag, " err"}, {31'b0, err}, {31'b0, exp_e});
    endtask

    task automatic t_reset();
        rst = 1'b1;
        for (int i = 0; i < DEPTH; i++) mdl[i] = 8'h00;
        mdl_r = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 rdata after reset", rdata, 32'h0);
        check("R1 err after reset", {31'b0, err}, 32'h0);
        access("R1 read 0", 1, 0, 0, 0, 1, 0);
        access("R1 read 60", 1, 0, 60, 0, 0, 0);
    endtask

    task automatic t_big_order();
        access("R2 write BE", 1, 1, 0, 32'hF498B70F, 1, 0);
        access("R4 read BE", 1, 0, 0, 0, 1, 0);
        check("R4 BE round trip", rdata, 32'hF498B70F);
        access("R2 read LE view", 1, 0, 0, 0, 0, 0);
        check("R2 byte0 is F4", {24'h0, rdata[7:0]}, 32'hF4);
    endtask

    task automatic t_little_order();
        access("R3 write LE", 1, 1, 8, 32'hF498B70F, 0, 0);
        access("R4 read LE", 1, 0, 8, 0, 0, 0);
        check("R4 LE round trip", rdata, 32'hF498B70F);
        access("R3 read BE view", 1, 0, 8, 0, 1, 0);
        check("R3 byte8 is 0F", {24'h0, rdata[31:24]}, 32'h0F);
        check("R3 reversed word", rdata, 32'h0FB798F4);
    endtask

    task automatic t_strict();
        access("R5 aligned 4 no err", 1, 1, 4, 32'hA1B2C3D4, 0, 0);
        access("R6 reject write at 5", 1, 1, 5, 32'hDEADBEEF, 0, 0);
        access("R6 err clears", 0, 0, 0, 0, 0, 0);
        access("R6 word 4 untouched", 1, 0, 4, 0, 0, 0);
        check("R6 word 4 value", rdata, 32'hA1B2C3D4);
        access("R6 word 8 untouched", 1, 0, 8, 0, 0, 0);
        access("R5 reject read at 2", 1, 0, 2, 0, 1, 0);
        check("R6 rdata zero", rdata, 32'h0);
        access("R5 reject read at 3", 1, 0, 3, 0, 0, 0);
    endtask

    task automatic t_permissive();
        access("R7 write wrap 62", 1, 1, 62, 32'h11223344, 0, 1);
        access("R7 read wrap 62", 1, 0, 62, 0, 0, 1);
        check("R7 wrap round trip", rdata, 32'h11223344);
        access("R7 read 0 BE", 1, 0, 0, 0, 1, 1);
        check("R7 wrapped bytes at 0", rdata, 32'h2211B70F);
        access("R7 write at 1 BE", 1, 1, 1, 32'hCAFE0123, 1, 1);
        access("R7 read at 3 LE", 1, 0, 3, 0, 0, 1);
        access("R7 read at 1 BE", 1, 0, 1, 0, 1, 1);
        check("R7 BE round trip at 1", rdata, 32'hCAFE0123);
    endtask

    task automatic t_idle_and_hold();
        access("R9 read before write", 1, 0, 4, 0, 0, 0);
        access("R9 write holds rdata", 1, 1, 20, 32'h55AA66BB, 1, 0);
        access("R8 idle with write data", 0, 1, 16, 32'h99887766, 1, 0);
        access("R8 idle misaligned no err", 0, 0, 17, 0, 0, 0);
        access("R8 word 16 unwritten", 1, 0, 16, 0, 1, 0);
        check("R8 word 16 zero", rdata, 32'h0);
        access("R9 read 20", 1, 0, 20, 0, 1, 0);
        check("R9 word 20", rdata, 32'h55AA66BB);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        t_reset();
        t_big_order();
        t_little_order();
        t_strict();
        t_permissive();
        t_idle_and_hold();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule